// File: doc/BRIEF.md
# Three-Comparator Up-Counter Timer with Synchronized Snapshot Read

This block is a single up-counting timer whose counter advances on a slow counting clock (in the region of 3.25 MHz). A faster bus clock carries a plain register write and read port. Software configures three match values, a restart value, and a selector that picks which comparator, if any, restarts the counter. A control bit then starts counting.

Each comparator keeps a sticky status bit that software clears by writing ones. An interrupt line is raised when any status bit is set whose enable bit is also set.

The live counter is never read across the clock boundary. Software writes 0x1 to the snapshot register. The request is carried into the counting domain as a toggle, and the count is captured there. An acknowledge toggle then carries the captured value back, and the bus side copies it into a stable register. Reads of the snapshot register return the most recent completed capture.

Top module: `mts_timer`

Register map (word addresses on `addr`): 0 control, 1 restart value, 2 restart selector, 3/4/5 match value of comparator 0/1/2, 6 status, 7 interrupt enable, 8 status clear, 9 snapshot.

## Requirements
- R1: After reset, all of the following read as zero: every register, the counter, the snapshot, the status bits and `irq`.
- R2: While control bit 0 (word 0) is 1, the counter adds one on every counting clock edge. While it is 0, the counter holds its value. A change of the bit takes effect on the third counting edge after the bus write.
- R3: Restart selector (word 2, bits [1:0]) values 1, 2 and 3 select comparator 0, 1 and 2. On an advancing edge where the count equals the selected match value, the counter loads the restart value (word 1) instead of adding one. Value 0 selects no restart, and the counter wraps modulo 2^CNT_W.
- R4: With the comparator 0 match value at all ones, restart value 0 and selector 1, the counter goes from all ones to 0 and keeps counting.
- R5: Status bit j (word 6, bit j) sets on any advancing edge where the count equals match value j. It stays set until it is cleared.
- R6: Writing word 8 clears every status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R7: `irq` is 1 exactly when some status bit j is set and interrupt enable bit j (word 7, bit j) is also 1.
- R8: Writing exactly 0x1 to word 9 requests a capture. Once the capture completes, reads of word 9 return the count at capture time, zero-extended. A write of any other value starts no capture. Between captures, word 9 holds its last captured value even while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| cnt_clk | input | 1 | Counting clock, asynchronous to bus_clk |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The bench builds the block with CNT_W = 8 and DATA_W = 32. This puts the all-ones wrap of R3 and R4 within 256 counting edges. The bench drives the counting clock edge by edge, so the count it expects after each run follows exactly from the number of edges and the restart rule. The stimulus table covers each selector value with restart values above and below the start point. A directed sequence then exercises partial clears, interrupt masking and a snapshot write that must be ignored.

// File: rtl/mts_pkg.sv
// Package: shared constants and the register map of the snapshot timer.
// Assumes exactly three comparators and a 4-bit word address.
package mts_pkg;
    localparam int N_CMP  = 3;
    localparam int SEL_W  = $clog2(N_CMP + 1);
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 4'd0,
        A_RESTART = 4'd1,
        A_RSEL    = 4'd2,
        A_MATCH0  = 4'd3,
        A_MATCH1  = 4'd4,
        A_MATCH2  = 4'd5,
        A_STATUS  = 4'd6,
        A_IEN     = 4'd7,
        A_ICLR    = 4'd8,
        A_SNAP    = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/mts_toggle_sync.sv
// Module: carries W independent toggle signals into a destination clock
// domain and turns every level change into a one-cycle pulse there.
// Assumes each source toggle is a flop output and changes no more often
// than once per two destination cycles.
module mts_toggle_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    input  logic [W-1:0] src_tgl,
    output logic [W-1:0] dst_pulse
);
    logic [STAGES:0][W-1:0] sh;

    // Shift the toggles through the synchronizer chain plus one history stage.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            sh <= '0;
        end else begin
            sh[0] <= src_tgl;
            for (int k = 1; k <= STAGES; k++) begin
                sh[k] <= sh[k-1];
            end
        end
    end

    assign dst_pulse = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/mts_counter.sv
// Module: counting-domain core. It holds the counter, the three comparators,
// the restart logic and the snapshot capture.
// Assumes the restart value, selector and match values from the bus domain
// are quasi-static: they are written while the timer is stopped.
module mts_counter
    import mts_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_async,
    input  logic [CNT_W-1:0]            restart_val,
    input  logic [SEL_W-1:0]            rsel,
    input  logic [N_CMP-1:0][CNT_W-1:0] match_val,
    input  logic                        snap_req_tgl,
    output logic [N_CMP-1:0]            match_tgl,
    output logic [CNT_W-1:0]            snap_cnt,
    output logic                        snap_ack_tgl
);
    logic             en_s1, en_s2;
    logic [CNT_W-1:0] count;
    logic [N_CMP-1:0] hit;
    logic             restart_hit;
    logic             req_pulse;

    // Two-flop synchronizer for the enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_s1 <= 1'b0;
            en_s2 <= 1'b0;
        end else begin
            en_s1 <= en_async;
            en_s2 <= en_s1;
        end
    end

    // One equality comparator per match value.
    genvar gj;
    generate
        for (gj = 0; gj < N_CMP; gj++) begin : g_cmp
            assign hit[gj] = (count == match_val[gj]);
        end
    endgenerate

    // Pick the comparator named by the selector; value 0 means no restart.
    always_comb begin
        restart_hit = 1'b0;
        for (int j = 0; j < N_CMP; j++) begin
            if (rsel == SEL_W'(j + 1) && hit[j]) begin
                restart_hit = 1'b1;
            end
        end
    end

    // Counter: advance or restart while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en_s2) begin
            count <= restart_hit ? restart_val : count + 1'b1;
        end
    end

    // Flip a match toggle on every advancing edge that sees that comparator hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_tgl <= '0;
        end else if (en_s2) begin
            match_tgl <= match_tgl ^ hit;
        end
    end

    mts_toggle_sync #(.W(1), .STAGES(2)) u_req_sync (
        .dst_clk   (clk),
        .dst_rst_n (rst_n),
        .src_tgl   (snap_req_tgl),
        .dst_pulse (req_pulse)
    );

    // Capture the count on a request and answer with an acknowledge toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_cnt     <= '0;
            snap_ack_tgl <= 1'b0;
        end else if (req_pulse) begin
            snap_cnt     <= count;
            snap_ack_tgl <= ~snap_ack_tgl;
        end
    end

    // R2: a stopped counter keeps its value.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s2 |=> $stable(count));

    // R2: an enabled counter without a restart hit adds exactly one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s2 && !restart_hit) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R3: a restart hit loads the restart value.
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s2 && restart_hit) |=> (count == $past(restart_val)));
endmodule

// File: rtl/mts_regs.sv
// Module: bus-domain register file. It holds the configuration, the sticky
// status, the interrupt mask, the snapshot request toggle and the stable
// snapshot copy. Reads are combinational from the addressed register.
// Assumes match pulses arrive already synchronized into this domain.
module mts_regs
    import mts_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic [N_CMP-1:0]            match_pulse,
    input  logic                        snap_ack_pulse,
    input  logic [CNT_W-1:0]            snap_cnt,
    output logic                        en,
    output logic [CNT_W-1:0]            restart_val,
    output logic [SEL_W-1:0]            rsel,
    output logic [N_CMP-1:0][CNT_W-1:0] match_val,
    output logic                        snap_req_tgl,
    output logic                        irq
);
    logic [N_CMP-1:0] status;
    logic [N_CMP-1:0] ien;
    logic [N_CMP-1:0] clr_mask;
    logic [CNT_W-1:0] snap_bus;
    logic             clr_wr;

    assign clr_wr   = wr_en && (addr == A_ICLR);
    assign clr_mask = clr_wr ? wdata[N_CMP-1:0] : '0;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en          <= 1'b0;
            restart_val <= '0;
            rsel        <= '0;
            ien         <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:    en          <= wdata[0];
                A_RESTART: restart_val <= wdata[CNT_W-1:0];
                A_RSEL:    rsel        <= wdata[SEL_W-1:0];
                A_IEN:     ien         <= wdata[N_CMP-1:0];
                default:   ;
            endcase
        end
    end

    // Match value registers, one word each from A_MATCH0 upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_val <= '0;
        end else begin
            for (int j = 0; j < N_CMP; j++) begin
                if (wr_en && addr == ADDR_W'(int'(A_MATCH0) + j)) begin
                    match_val[j] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    // Sticky status: a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | match_pulse;
        end
    end

    // Snapshot request toggle and the stable bus-side copy of the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_req_tgl <= 1'b0;
            snap_bus     <= '0;
        end else begin
            if (wr_en && addr == A_SNAP && wdata == DATA_W'(1)) begin
                snap_req_tgl <= ~snap_req_tgl;
            end
            if (snap_ack_pulse) begin
                snap_bus <= snap_cnt;
            end
        end
    end

    // Read multiplexer for the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:    rdata = DATA_W'(en);
            A_RESTART: rdata = DATA_W'(restart_val);
            A_RSEL:    rdata = DATA_W'(rsel);
            A_STATUS:  rdata = DATA_W'(status);
            A_IEN:     rdata = DATA_W'(ien);
            A_SNAP:    rdata = DATA_W'(snap_bus);
            default: begin
                for (int j = 0; j < N_CMP; j++) begin
                    if (addr == ADDR_W'(int'(A_MATCH0) + j)) begin
                        rdata = DATA_W'(match_val[j]);
                    end
                end
            end
        endcase
    end

    assign irq = |(status & ien);

    // R5: status bits only fall through a clear write.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status)));

    // R6: a cleared bit is low afterwards unless a match set it again.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & $past(wdata[N_CMP-1:0]) & ~$past(match_pulse)) == '0));

    // R8: the readable snapshot only changes on a completed capture.
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_ack_pulse |=> $stable(snap_bus));
endmodule

// File: rtl/mts_timer.sv
// Module: top of the snapshot timer. It joins the bus-domain register file,
// the counting-domain core and the synchronizers that carry the match and
// acknowledge toggles back to the bus side.
// Assumes rst_n is held low for at least three edges of each clock, and the
// bus clock runs well above the counting clock.
module mts_timer
    import mts_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              cnt_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic                        en;
    logic [CNT_W-1:0]            restart_val;
    logic [SEL_W-1:0]            rsel;
    logic [N_CMP-1:0][CNT_W-1:0] match_val;
    logic                        snap_req_tgl;
    logic [N_CMP-1:0]            match_tgl;
    logic [N_CMP-1:0]            match_pulse;
    logic [CNT_W-1:0]            snap_cnt;
    logic                        snap_ack_tgl;
    logic                        snap_ack_pulse;

    mts_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk            (bus_clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .addr           (addr),
        .wdata          (wdata),
        .rdata          (rdata),
        .match_pulse    (match_pulse),
        .snap_ack_pulse (snap_ack_pulse),
        .snap_cnt       (snap_cnt),
        .en             (en),
        .restart_val    (restart_val),
        .rsel           (rsel),
        .match_val      (match_val),
        .snap_req_tgl   (snap_req_tgl),
        .irq            (irq)
    );

    mts_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (cnt_clk),
        .rst_n        (rst_n),
        .en_async     (en),
        .restart_val  (restart_val),
        .rsel         (rsel),
        .match_val    (match_val),
        .snap_req_tgl (snap_req_tgl),
        .match_tgl    (match_tgl),
        .snap_cnt     (snap_cnt),
        .snap_ack_tgl (snap_ack_tgl)
    );

    mts_toggle_sync #(.W(N_CMP), .STAGES(2)) u_match_sync (
        .dst_clk   (bus_clk),
        .dst_rst_n (rst_n),
        .src_tgl   (match_tgl),
        .dst_pulse (match_pulse)
    );

    mts_toggle_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .dst_clk   (bus_clk),
        .dst_rst_n (rst_n),
        .src_tgl   (snap_ack_tgl),
        .dst_pulse (snap_ack_pulse)
    );
endmodule

// File: tb/mts_timer_test.sv
module mts_timer_test;
    localparam int CW = 8;
    localparam int DW = 32;

    logic          bus_clk = 1'b0;
    logic          cnt_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          wr_en   = 1'b0;
    logic [3:0]    addr    = '0;
    logic [DW-1:0] wdata   = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    mts_timer #(.CNT_W(CW), .DATA_W(DW)) uut (
        .bus_clk (bus_clk), .cnt_clk (cnt_clk), .rst_n (rst_n),
        .wr_en (wr_en), .addr (addr), .wdata (wdata),
        .rdata (rdata), .irq (irq)
    );

    always #5 bus_clk = ~bus_clk;

    typedef struct packed {
        logic [7:0]  rst_v;
        logic [1:0]  sel;
        logic [7:0]  m0;
        logic [7:0]  m1;
        logic [7:0]  m2;
        logic [15:0] n;
        logic [7:0]  exp_cnt;
        logic [2:0]  exp_st;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd0,  2'd0, 8'd3,   8'd9,   8'd200, 16'd10,  8'd10, 3'b011},
        '{8'd2,  2'd1, 8'd5,   8'd7,   8'd1,   16'd10,  8'd2,  3'b101},
        '{8'd10, 2'd2, 8'd20,  8'd3,   8'd0,   16'd8,   8'd14, 3'b110},
        '{8'd0,  2'd3, 8'd0,   8'd7,   8'd4,   16'd12,  8'd2,  3'b101},
        '{8'd0,  2'd1, 8'hFF,  8'h80,  8'hFE,  16'd260, 8'd4,  3'b111},
        '{8'd0,  2'd0, 8'hFF,  8'h01,  8'hFE,  16'd258, 8'd2,  3'b111}
    };

    task automatic check(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [DW-1:0] v);
        @(negedge bus_clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic cnt_pulses(input int n);
        @(negedge bus_clk);
        for (int i = 0; i < n; i++) begin
            cnt_clk = 1'b1; #20;
            cnt_clk = 1'b0; #20;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cnt_pulses(3);
        @(negedge bus_clk);
        rst_n = 1'b1;
    endtask

    task automatic snapshot();
        bus_write(4'd9, 32'h1);
        cnt_pulses(4);
        repeat (8) @(negedge bus_clk);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        do_reset();
        // R1: reset state
        read_reg(4'd0, v); check("R1 control", v, 0);
        read_reg(4'd6, v); check("R1 status", v, 0);
        read_reg(4'd9, v); check("R1 snapshot", v, 0);
        read_reg(4'd3, v); check("R1 match0", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2: counting edges without enable leave the counter at zero
        bus_write(4'd3, 32'd50);
        cnt_pulses(10);
        snapshot();
        read_reg(4'd9, v); check("R2 hold while disabled", v, 0);

        // Table walk: R2 R3 R4 R5 R8
        for (int k = 0; k < 6; k++) begin
            do_reset();
            bus_write(4'd1, 32'(VECS[k].rst_v));
            bus_write(4'd2, 32'(VECS[k].sel));
            bus_write(4'd3, 32'(VECS[k].m0));
            bus_write(4'd4, 32'(VECS[k].m1));
            bus_write(4'd5, 32'(VECS[k].m2));
            bus_write(4'd0, 32'h1);
            cnt_pulses(int'(VECS[k].n));
            bus_write(4'd0, 32'h0);
            cnt_pulses(4);
            snapshot();
            read_reg(4'd9, v);
            check($sformatf("R2 R3 R4 R8 vector %0d count", k), v, 32'(VECS[k].exp_cnt));
            read_reg(4'd6, v);
            check($sformatf("R5 vector %0d status", k), v, 32'(VECS[k].exp_st));
        end

        // R6 and R7 on status 3'b111 left by the last vector
        check("R7 irq masked by zero enable", {31'd0, irq}, 0);
        bus_write(4'd8, 32'h2);
        read_reg(4'd6, v); check("R6 clear bit1 only", v, 32'h5);
        bus_write(4'd7, 32'h2);
        read_reg(4'd7, v); check("R7 enable readback", v, 32'h2);
        check("R7 irq enable on cleared bit", {31'd0, irq}, 0);
        bus_write(4'd7, 32'h4);
        check("R7 irq raised by bit2", {31'd0, irq}, 1);
        bus_write(4'd8, 32'h4);
        check("R7 irq drops after clear", {31'd0, irq}, 0);
        read_reg(4'd6, v); check("R6 clear bit2 keeps bit0", v, 32'h1);

        // R8: a value other than 0x1 starts no capture; the old value remains
        bus_write(4'd0, 32'h1);
        cnt_pulses(5);
        bus_write(4'd0, 32'h0);
        cnt_pulses(4);
        bus_write(4'd9, 32'h2);
        cnt_pulses(4);
        repeat (8) @(negedge bus_clk);
        read_reg(4'd9, v); check("R8 non-request write ignored", v, 32'd2);
        snapshot();
        read_reg(4'd9, v); check("R8 new capture", v, 32'd7);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule